// File: doc/BRIEF.md
# DRAM refresh address generator

This block holds two 8-bit registers of a processor core: the refresh counter and the interrupt page register. The sequencer pulses `fetch_done_i` once for each completed opcode fetch. On that pulse the refresh counter advances in its low seven bits only, and its top bit keeps whatever value software last wrote. Software writes and reads both registers through dedicated load strobes, a shared data byte and two readback ports.

While the decoding of the fetched opcode is under way, the sequencer raises `rfsh_win_i` to mark the refresh slot. For every cycle the window is high, the block puts the page register on the upper address byte and the refresh counter on the lower byte, and pulls the refresh and memory-request strobes low together. The slot lies inside the decode time, so it costs the instruction stream no cycles. Memories use only the lower seven address bits as the row address. Outside the window the strobes stay high and the block does not drive the bus.

The outputs are registered. The address, the strobes and the bus-drive flag in cycle t+1 show the window input and the register contents as they stood in cycle t.

Top module: `rfsh_addr_gen`

## Requirements
- R1: A clock edge with `rst_n` low clears the refresh counter and the page register to 0x00. After that edge, `rfsh_n_o` and `mreq_n_o` are 1, `addr_drive_o` is 0 and `addr_o` is 0x0000.
- R2: A clock edge with `fetch_done_i` high and `ld_rcnt_i` low adds one to bits 6:0 of the refresh counter, wrapping from 0x7F to 0x00 within those bits.
- R3: Incrementing never changes bit 7 of the refresh counter. That bit keeps the value from the last load or reset.
- R4: A clock edge with `ld_rcnt_i` high loads `ld_data_i` into the refresh counter, even when `fetch_done_i` is high in the same cycle.
- R5: A clock edge with `ld_page_i` high loads `ld_data_i` into the page register. The refresh counter is not affected.
- R6: After a clock edge with `rfsh_win_i` high, `addr_o[15:8]` equals the page register and `addr_o[7:0]` equals the refresh counter, both as they stood before that edge. At the same time `addr_drive_o` is 1 and `rfsh_n_o` and `mreq_n_o` are both 0.
- R7: After a clock edge with `rfsh_win_i` low, `rfsh_n_o` and `mreq_n_o` are 1, `addr_drive_o` is 0 and `addr_o` is 0x0000.
- R8: `rfsh_n_o` and `mreq_n_o` are equal in every cycle.
- R9: With `fetch_done_i`, `ld_rcnt_i` and `ld_page_i` all low, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_done_i | input | 1 | One-cycle pulse per completed opcode fetch |
| rfsh_win_i | input | 1 | Refresh slot window from the sequencer |
| ld_rcnt_i | input | 1 | Load strobe for the refresh counter |
| ld_page_i | input | 1 | Load strobe for the page register |
| ld_data_i | input | 8 | Data for either load |
| addr_o | output | 16 | Refresh address, zero when not driving |
| addr_drive_o | output | 1 | High while the block owns the address bus |
| rfsh_n_o | output | 1 | Refresh strobe, active low |
| mreq_n_o | output | 1 | Memory request strobe, active low |
| rcnt_o | output | 8 | Refresh counter readback |
| page_o | output | 8 | Page register readback |

## Verification
A counter that has gone wrong shows up on `rcnt_o` one cycle after the faulty edge. It then shows on the low address byte during the next refresh slot. The important cases are a carry leaking into bit 7 at the 0x7F wrap and an increment that wins over a same-cycle load. Both are visible one cycle after the edge that causes them. A fault in the output stage, such as a wrong byte order, strobes that split, or address bits left driven outside the slot, shows on the address and strobe pins in the cycle after the window sample.

// File: rtl/rfsh_pkg.sv
// Package: shared widths and types for the refresh address generator.
// Assumes an 8-bit register file and a 16-bit address bus.
package rfsh_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2 * REG_W;
    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/rfsh_counter.sv
// Refresh counter: the low CNT_BITS bits advance on each fetch pulse and wrap.
// The remaining high bits change only on an explicit load or a reset.
// Assumes a synchronous active-low reset. A load takes priority over an increment.
module rfsh_counter
    import rfsh_pkg::*;
#(
    parameter int CNT_BITS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bump_i,
    input  logic ld_i,
    input  reg_t data_i,
    output reg_t cnt_o
);
    localparam int HOLD_BITS = REG_W - CNT_BITS;

    reg_t cnt_q;
    reg_t cnt_next;

    // Next value: the low field increments, and any held bits pass through unchanged.
    generate
        if (HOLD_BITS > 0) begin : g_split
            always_comb begin
                cnt_next = {cnt_q[REG_W-1:CNT_BITS], cnt_q[CNT_BITS-1:0] + 1'b1};
            end
        end else begin : g_full
            always_comb begin
                cnt_next = cnt_q + 1'b1;
            end
        end
    endgenerate

    // Register update: reset, then load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (ld_i)   cnt_q <= data_i;
        else if (bump_i) cnt_q <= cnt_next;
    end

    assign cnt_o = cnt_q;

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && !ld_i) |=> cnt_q[CNT_BITS-1:0] == CNT_BITS'($past(cnt_q[CNT_BITS-1:0]) + 1'b1));

    p_msb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && !ld_i) |=> cnt_q[REG_W-1] == $past(cnt_q[REG_W-1]));

    p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> cnt_q == $past(data_i));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bump_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/page_reg.sv
// Page register: holds the upper refresh address byte, loaded by software.
// Assumes a synchronous active-low reset. It has no other update path.
module page_reg
    import rfsh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_i,
    input  reg_t data_i,
    output reg_t page_o
);
    reg_t page_q;

    // Register update: reset, then load.
    always_ff @(posedge clk) begin
        if (!rst_n)    page_q <= '0;
        else if (ld_i) page_q <= data_i;
    end

    assign page_o = page_q;

    p_page_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> page_q == $past(data_i));

    p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_i |=> $stable(page_q));
endmodule

// File: rtl/rfsh_drive.sv
// Output stage: registers the refresh address and strobes from the window input.
// The address is zero and the drive flag low whenever the window was low.
// Assumes a window sampled at a clock edge appears on the pins one cycle later.
module rfsh_drive
    import rfsh_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  win_i,
    input  reg_t  page_i,
    input  reg_t  cnt_i,
    output addr_t addr_o,
    output logic  drive_o,
    output logic  rfsh_n_o,
    output logic  mreq_n_o
);
    addr_t addr_q;
    logic  drive_q;
    logic  rfsh_n_q;
    logic  mreq_n_q;

    // Output registers: capture the address and strobes for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            drive_q  <= 1'b0;
            rfsh_n_q <= 1'b1;
            mreq_n_q <= 1'b1;
        end else begin
            addr_q   <= win_i ? {page_i, cnt_i} : '0;
            drive_q  <= win_i;
            rfsh_n_q <= !win_i;
            mreq_n_q <= !win_i;
        end
    end

    assign addr_o   = addr_q;
    assign drive_o  = drive_q;
    assign rfsh_n_o = rfsh_n_q;
    assign mreq_n_o = mreq_n_q;

    p_slot_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_i |=> (addr_o == {$past(page_i), $past(cnt_i)}) && drive_o && !rfsh_n_o);

    p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_i |=> (addr_o == '0) && !drive_o && rfsh_n_o);

    p_strobe_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_n_o == mreq_n_o);
endmodule

// File: rtl/rfsh_addr_gen.sv
// Top: the refresh counter, the page register and the output stage.
// Assumes the sequencer raises the window only during the refresh slot
// and pulses fetch_done_i for exactly one cycle per opcode fetch.
module rfsh_addr_gen
    import rfsh_pkg::*;
#(
    parameter int CNT_BITS = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_done_i,
    input  logic        rfsh_win_i,
    input  logic        ld_rcnt_i,
    input  logic        ld_page_i,
    input  logic [7:0]  ld_data_i,
    output logic [15:0] addr_o,
    output logic        addr_drive_o,
    output logic        rfsh_n_o,
    output logic        mreq_n_o,
    output logic [7:0]  rcnt_o,
    output logic [7:0]  page_o
);
    reg_t cnt_w;
    reg_t page_w;

    rfsh_counter #(.CNT_BITS(CNT_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bump_i(fetch_done_i),
        .ld_i(ld_rcnt_i), .data_i(ld_data_i), .cnt_o(cnt_w)
    );

    page_reg u_page (
        .clk(clk), .rst_n(rst_n), .ld_i(ld_page_i),
        .data_i(ld_data_i), .page_o(page_w)
    );

    rfsh_drive u_drv (
        .clk(clk), .rst_n(rst_n), .win_i(rfsh_win_i),
        .page_i(page_w), .cnt_i(cnt_w), .addr_o(addr_o),
        .drive_o(addr_drive_o), .rfsh_n_o(rfsh_n_o), .mreq_n_o(mreq_n_o)
    );

    assign rcnt_o = cnt_w;
    assign page_o = page_w;

    // R1: the registers read zero in the cycle after a reset edge.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rcnt_o == 8'h00) && (page_o == 8'h00) && rfsh_n_o && !addr_drive_o);
endmodule

// File: tb/rfsh_addr_gen_tb.sv
module rfsh_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        fetch_done_i, rfsh_win_i, ld_rcnt_i, ld_page_i;
    logic [7:0]  ld_data_i;
    logic [15:0] addr_o;
    logic        addr_drive_o, rfsh_n_o, mreq_n_o;
    logic [7:0]  rcnt_o, page_o;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    rfsh_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_done_i(fetch_done_i), .rfsh_win_i(rfsh_win_i),
        .ld_rcnt_i(ld_rcnt_i), .ld_page_i(ld_page_i), .ld_data_i(ld_data_i),
        .addr_o(addr_o), .addr_drive_o(addr_drive_o), .rfsh_n_o(rfsh_n_o),
        .mreq_n_o(mreq_n_o), .rcnt_o(rcnt_o), .page_o(page_o)
    );

    // Row bits: {fetch, ld_rcnt, ld_page, win, data[7:0], exp_rcnt[7:0], exp_page[7:0]}
    localparam int NV = 12;
    localparam logic [27:0] VEC [NV] = '{
        {4'b0010, 8'h3F, 8'h00, 8'h3F},  // R5 page load
        {4'b1000, 8'h00, 8'h01, 8'h3F},  // R2 increment
        {4'b0001, 8'h00, 8'h01, 8'h3F},  // R6 window, R9 hold
        {4'b0100, 8'h7E, 8'h7E, 8'h3F},  // R4 plain load
        {4'b1000, 8'h00, 8'h7F, 8'h3F},  // R2
        {4'b1000, 8'h00, 8'h00, 8'h3F},  // R2 wrap to 0x00
        {4'b0100, 8'hFF, 8'hFF, 8'h3F},  // R4 load with bit 7 set
        {4'b1000, 8'h00, 8'h80, 8'h3F},  // R3 wrap keeps bit 7
        {4'b1100, 8'h55, 8'h55, 8'h3F},  // R4 load beats increment
        {4'b1001, 8'h00, 8'h56, 8'h3F},  // R6 address uses 0x3F55
        {4'b0000, 8'h00, 8'h56, 8'h3F},  // R9 idle hold, R7
        {4'b1010, 8'hA0, 8'h57, 8'hA0}   // R5 page load leaves the counter to R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bus(input logic win, input logic [15:0] exp_addr);
        chk(win ? "R6 drive" : "R7 drive", {31'd0, addr_drive_o}, {31'd0, win});
        chk(win ? "R6 rfsh" : "R7 rfsh", {31'd0, rfsh_n_o}, {31'd0, !win});
        chk(win ? "R6 addr" : "R7 addr", {16'd0, addr_o}, {16'd0, win ? exp_addr : 16'h0000});
        chk("R8 strobe pair", {31'd0, mreq_n_o}, {31'd0, rfsh_n_o});
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] prev_r, prev_i;
        rst_n = 1'b0; fetch_done_i = 1'b1; rfsh_win_i = 1'b1;
        ld_rcnt_i = 1'b1; ld_page_i = 1'b1; ld_data_i = 8'hC3;
        repeat (3) @(posedge clk);
        #2;
        // R1: a reset edge overrides every active input.
        chk("R1 rcnt", {24'd0, rcnt_o}, 32'h00);
        chk("R1 page", {24'd0, page_o}, 32'h00);
        chk_bus(1'b0, 16'h0000);
        rst_n = 1'b1; fetch_done_i = 1'b0; rfsh_win_i = 1'b0;
        ld_rcnt_i = 1'b0; ld_page_i = 1'b0; ld_data_i = 8'h00;
        prev_r = 8'h00; prev_i = 8'h00;

        for (int k = 0; k < NV; k++) begin
            {fetch_done_i, ld_rcnt_i, ld_page_i, rfsh_win_i} = VEC[k][27:24];
            ld_data_i = VEC[k][23:16];
            @(posedge clk);
            #2;
            chk("R2/R3/R4/R9 rcnt", {24'd0, rcnt_o}, {24'd0, VEC[k][15:8]});
            chk("R5/R9 page", {24'd0, page_o}, {24'd0, VEC[k][7:0]});
            chk_bus(VEC[k][24], {prev_i, prev_r});
            prev_r = VEC[k][15:8];
            prev_i = VEC[k][7:0];
        end

        // R6: a window held for two cycles tracks a count that changes in between.
        fetch_done_i = 1'b1; ld_rcnt_i = 1'b0; ld_page_i = 1'b0; rfsh_win_i = 1'b1;
        @(posedge clk); #2;
        chk_bus(1'b1, 16'hA057);
        fetch_done_i = 1'b0;
        @(posedge clk); #2;
        chk_bus(1'b1, 16'hA058);
        rfsh_win_i = 1'b0;
        @(posedge clk); #2;
        chk_bus(1'b0, 16'h0000);

        // R1: a reset in the middle of a run clears both registers again.
        rst_n = 1'b0;
        @(posedge clk); #2;
        chk("R1 mid rcnt", {24'd0, rcnt_o}, 32'h00);
        chk("R1 mid page", {24'd0, page_o}, 32'h00);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule